// File: doc/BRIEF.md
# Dual Serial PCM Port

This block connects two independent serial PCM lanes to a parallel word interface. All lanes share one bit clock. Each port has its own strobe, one serial data input and one serial data output with an output enable. While a port's strobe is high, the port shifts in one received word and shifts out one transmit word, most significant bit first. The number of bit-clock cycles inside the strobe window fixes the received word length, which is either 8 bits for companded codes or 16 bits for two's complement linear samples. The two ports run separately, so one port can carry 8-bit frames while the other carries 16-bit frames.

Received bits are sampled on the falling edge of the bit clock. Transmit bits are launched on the rising edge. The parallel side always works in sign-magnitude code for 8-bit words. The serial side can carry either that code or its G.711 form, where mu-law inverts every bit and A-law flips the even-numbered bits (XOR with 0x55). The bit clock may stop between frames, as long as one full clock cycle has run after the strobe drops. When a frame completes, the port raises a one-cycle completion pulse, or an error pulse if the cycle count was not valid.

Top module: `pcm_dual_port`

## Requirements
- R1: While reset is asserted and right after it is released, every `sdo` and `sdo_oe` bit is 0, every `rx_done` and `rx_err` bit is 0, and every `rx_word` is zero.
- R2: Serial input is sampled on falling bit-clock edges while the port's strobe is high, first bit as the most significant. A window of exactly 16 falling edges delivers the 16 sampled bits unchanged on `rx_word`.
- R3: A window of exactly 8 falling edges delivers an 8-bit code in `rx_word[7:0]`, with `rx_word[15:8]` zero. With `cfg_fmt` = 0 (sign-magnitude) the code is passed through as received.
- R4: With `cfg_fmt` = 1 (G.711), the code is translated between line and parallel form by XOR with 0xFF when `cfg_law` = 0 (mu-law) and with 0x55 when `cfg_law` = 1 (A-law). The same rule applies in both directions: on receive the configuration is the one present at frame completion, and on transmit it is the one present at load.
- R5: At the first rising edge with the strobe high, the transmit word is loaded, so its first bit is on `sdo` before the first sampling falling edge. With `tx_wide` = 1, `tx_word[15:0]` is sent most significant bit first, one bit per rising edge, and zeros follow if the window runs past 16 bits.
- R6: With `tx_wide` = 0, the line code derived from `tx_word[7:0]` (per R4) is sent as the first 8 bits, followed by zeros.
- R7: `sdo_oe` is high only while the strobe is high and after the window's first rising edge. Whenever `sdo_oe` is low, `sdo` is 0, which stands for the high-impedance state at the pad.
- R8: At the first falling edge where the strobe is sampled low after a window of 8 or 16 bits, `rx_done` goes high for exactly one bit-clock period and `rx_word` updates at that same edge. `rx_word` changes at no other time.
- R9: If the window held any count of falling edges other than 8 or 16, `rx_err` pulses for one period in place of `rx_done`, and `rx_word` keeps its previous value.
- R10: Serial input applied while the strobe is low, including while the bit clock is stopped, does not affect any later received word or any output.
- R11: Each port's length, format and law are independent, so frames of different lengths and codes on the two ports in the same interval each complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Shared bit clock; may stop between frames |
| rst_n | input | 1 | Asynchronous reset, active low |
| ena | input | NPORT | Per-port strobe, high during the frame window |
| sdi | input | NPORT | Per-port serial data in |
| sdo | output | NPORT | Per-port serial data out, 0 when not enabled |
| sdo_oe | output | NPORT | Per-port output enable for the pad driver |
| cfg_fmt | input | NPORT | 8-bit code form: 0 sign-magnitude, 1 G.711 |
| cfg_law | input | NPORT | G.711 law: 0 mu-law, 1 A-law |
| tx_wide | input | NPORT | Transmit length: 1 sends 16 bits, 0 sends an 8-bit code |
| tx_word | input | NPORT x WIDE_W | Parallel transmit word per port |
| rx_word | output | NPORT x WIDE_W | Last completed received word per port |
| rx_done | output | NPORT | One-period pulse when a valid frame completes |
| rx_err | output | NPORT | One-period pulse when a frame has a bad length |

## Verification
The assertions rely on four conditions. The strobe changes only while the bit clock is low, and serial input changes only after a rising edge. At least one full bit-clock cycle runs with the strobe low before the clock stops or a new window opens. The format, law and transmit-length inputs stay steady during a window. The bench keeps to all of these: it raises and drops each strobe just after a falling edge, drives data just after a rising edge, and leaves three idle cycles between frames. It changes the configuration only during those idle cycles. It stops the gated clock only after those idle cycles, and it only does so while the clock is low.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Width of one companded code on the line.
    localparam int CODE_W = 8;

    // Code-form and law selections carried on the cfg inputs.
    localparam logic FMT_SIGNMAG = 1'b0;
    localparam logic FMT_G711    = 1'b1;
    localparam logic LAW_MU      = 1'b0;
    localparam logic LAW_A       = 1'b1;

    localparam logic [CODE_W-1:0] MU_FLIP = 8'hFF;
    localparam logic [CODE_W-1:0] A_FLIP  = 8'h55;

    // XOR pattern between sign-magnitude and line code; self-inverse.
    function automatic logic [CODE_W-1:0] code_flip(input logic fmt, input logic law);
        logic [CODE_W-1:0] m;
        m = '0;
        if (fmt == FMT_G711) begin
            m = (law == LAW_A) ? A_FLIP : MU_FLIP;
        end
        return m;
    endfunction

endpackage

// File: rtl/pcm_code_xlat.sv
module pcm_code_xlat
    import pcm_port_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              fmt_i,
    input  logic              law_i,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        code_o = code_i ^ code_flip(fmt_i, law_i);
    end

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_port_pkg::*;
#(
    parameter int WIDE_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              ena_i,
    input  logic              sdi_i,
    input  logic              fmt_i,
    input  logic              law_i,
    output logic [WIDE_W-1:0] word_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(2 * WIDE_W);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_WIDE   = CNT_W'(WIDE_W);
    localparam logic [CNT_W-1:0] CNT_NARROW = CNT_W'(CODE_W);

    typedef struct packed {
        logic [WIDE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic [WIDE_W-1:0] word;
        logic              done;
        logic              err;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [CODE_W-1:0] sm_code;

    // Line code in the low bits becomes sign-magnitude for the parallel side.
    pcm_code_xlat u_xlat (
        .code_i (st_q.sr[CODE_W-1:0]),
        .fmt_i  (fmt_i),
        .law_i  (law_i),
        .code_o (sm_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (ena_i) begin
            st_d.sr = {st_q.sr[WIDE_W-2:0], sdi_i};
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            // First falling edge after the window: close the frame.
            st_d.cnt = '0;
            if (st_q.cnt == CNT_WIDE) begin
                st_d.word = st_q.sr;
                st_d.done = 1'b1;
            end else if (st_q.cnt == CNT_NARROW) begin
                st_d.word               = '0;
                st_d.word[CODE_W-1:0]   = sm_code;
                st_d.done               = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_port_pkg::*;
#(
    parameter int WIDE_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              ena_i,
    input  logic [WIDE_W-1:0] word_i,
    input  logic              wide_i,
    input  logic              fmt_i,
    input  logic              law_i,
    output logic              sdo_o,
    output logic              oe_o
);

    typedef struct packed {
        logic [WIDE_W-1:0] sr;
        logic              act;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [CODE_W-1:0] line_code;
    logic [WIDE_W-1:0] load_val;

    // Sign-magnitude parallel code becomes the line code.
    pcm_code_xlat u_xlat (
        .code_i (word_i[CODE_W-1:0]),
        .fmt_i  (fmt_i),
        .law_i  (law_i),
        .code_o (line_code)
    );

    always_comb begin
        load_val = '0;
        if (wide_i) begin
            load_val = word_i;
        end else begin
            load_val[WIDE_W-1 -: CODE_W] = line_code;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.act = ena_i;
        if (ena_i) begin
            if (!st_q.act) begin
                st_d.sr = load_val;
            end else begin
                st_d.sr = {st_q.sr[WIDE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Drive only inside the window and after its first launch edge.
    assign oe_o  = st_q.act & ena_i;
    assign sdo_o = oe_o & st_q.sr[WIDE_W-1];

endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port
    import pcm_port_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int WIDE_W = 16
) (
    input  logic                         bclk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             ena,
    input  logic [NPORT-1:0]             sdi,
    output logic [NPORT-1:0]             sdo,
    output logic [NPORT-1:0]             sdo_oe,
    input  logic [NPORT-1:0]             cfg_fmt,
    input  logic [NPORT-1:0]             cfg_law,
    input  logic [NPORT-1:0]             tx_wide,
    input  logic [NPORT-1:0][WIDE_W-1:0] tx_word,
    output logic [NPORT-1:0][WIDE_W-1:0] rx_word,
    output logic [NPORT-1:0]             rx_done,
    output logic [NPORT-1:0]             rx_err
);

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            pcm_rx_lane #(.WIDE_W(WIDE_W)) u_rx (
                .bclk   (bclk),
                .rst_n  (rst_n),
                .ena_i  (ena[g]),
                .sdi_i  (sdi[g]),
                .fmt_i  (cfg_fmt[g]),
                .law_i  (cfg_law[g]),
                .word_o (rx_word[g]),
                .done_o (rx_done[g]),
                .err_o  (rx_err[g])
            );

            pcm_tx_lane #(.WIDE_W(WIDE_W)) u_tx (
                .bclk   (bclk),
                .rst_n  (rst_n),
                .ena_i  (ena[g]),
                .word_i (tx_word[g]),
                .wide_i (tx_wide[g]),
                .fmt_i  (cfg_fmt[g]),
                .law_i  (cfg_law[g]),
                .sdo_o  (sdo[g]),
                .oe_o   (sdo_oe[g])
            );
        end
    endgenerate

endmodule

// File: rtl/pcm_dual_port_chk.sv
module pcm_dual_port_chk #(
    parameter int NPORT  = 2,
    parameter int WIDE_W = 16
) (
    input logic                         bclk,
    input logic                         rst_n,
    input logic [NPORT-1:0]             ena,
    input logic [NPORT-1:0]             sdo,
    input logic [NPORT-1:0]             sdo_oe,
    input logic [NPORT-1:0][WIDE_W-1:0] rx_word,
    input logic [NPORT-1:0]             rx_done,
    input logic [NPORT-1:0]             rx_err
);

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_chk
            AST_PAD_OFF_WITHOUT_STROBE: assert property (@(negedge bclk) disable iff (!rst_n)
                !ena[g] |-> !sdo_oe[g]) else $error("pad enabled outside window"); // R7

            AST_SILENT_WHEN_OFF: assert property (@(negedge bclk) disable iff (!rst_n)
                !sdo_oe[g] |-> !sdo[g]) else $error("data driven while disabled"); // R7

            AST_DONE_ONE_PERIOD: assert property (@(negedge bclk) disable iff (!rst_n)
                rx_done[g] |=> !rx_done[g]) else $error("done longer than one period"); // R8

            AST_DONE_FOLLOWS_STROBE_LOW: assert property (@(negedge bclk) disable iff (!rst_n)
                rx_done[g] |-> !$past(ena[g])) else $error("done without closed window"); // R8

            AST_WORD_ONLY_ON_DONE: assert property (@(negedge bclk) disable iff (!rst_n)
                !rx_done[g] |-> $stable(rx_word[g])) else $error("word moved without done"); // R8

            AST_ERR_EXCLUDES_DONE: assert property (@(negedge bclk) disable iff (!rst_n)
                !(rx_err[g] && rx_done[g])) else $error("error and done together"); // R9

            AST_ERR_KEEPS_WORD: assert property (@(negedge bclk) disable iff (!rst_n)
                rx_err[g] |-> $stable(rx_word[g])) else $error("bad frame changed word"); // R9
        end
    endgenerate

endmodule

bind pcm_dual_port pcm_dual_port_chk #(
    .NPORT  (NPORT),
    .WIDE_W (WIDE_W)
) u_chk (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .ena     (ena),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .rx_word (rx_word),
    .rx_done (rx_done),
    .rx_err  (rx_err)
);

// File: tb/pcm_dual_port_tb.sv
module pcm_dual_port_tb;

    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;
    localparam int NP     = 2;
    localparam int W      = 16;

    logic             bclk_free = 1'b0;
    logic             clk_run   = 1'b1;
    logic             bclk;
    logic             rst_n     = 1'b0;
    logic [NP-1:0]    ena       = '0;
    logic [NP-1:0]    sdi       = '0;
    logic [NP-1:0]    sdo;
    logic [NP-1:0]    sdo_oe;
    logic [NP-1:0]    cfg_fmt   = '0;
    logic [NP-1:0]    cfg_law   = '0;
    logic [NP-1:0]    tx_wide   = '0;
    logic [NP-1:0][W-1:0] tx_word = '0;
    logic [NP-1:0][W-1:0] rx_word;
    logic [NP-1:0]    rx_done;
    logic [NP-1:0]    rx_err;

    int checks = 0;
    int errors = 0;
    int done_cnt [NP];
    int err_cnt  [NP];
    int nlen     [NP];
    logic [31:0] rxpat [NP];
    bit finished = 0;

    always #(HALF) bclk_free = ~bclk_free;
    assign bclk = bclk_free & clk_run;

    pcm_dual_port #(.NPORT(NP), .WIDE_W(W)) u_dut (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .ena     (ena),
        .sdi     (sdi),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .cfg_fmt (cfg_fmt),
        .cfg_law (cfg_law),
        .tx_wide (tx_wide),
        .tx_word (tx_word),
        .rx_word (rx_word),
        .rx_done (rx_done),
        .rx_err  (rx_err)
    );

    initial begin
        for (int p = 0; p < NP; p++) begin
            done_cnt[p] = 0;
            err_cnt[p]  = 0;
        end
    end

    // Pulse monitor: one sample per falling edge, so a long pulse counts twice.
    always @(negedge bclk) begin
        #2;
        for (int p = 0; p < NP; p++) begin
            if (rx_done[p] === 1'b1) done_cnt[p]++;
            if (rx_err[p]  === 1'b1) err_cnt[p]++;
        end
    end

    function automatic logic [7:0] flip_of(input logic fmt, input logic law);
        return fmt ? (law ? 8'h55 : 8'hFF) : 8'h00;
    endfunction

    function automatic logic tx_bit(input logic [W-1:0] w, input logic wide,
                                    input logic fmt, input logic law, input int c);
        logic [W-1:0] line;
        line = wide ? w : {w[7:0] ^ flip_of(fmt, law), 8'h00};
        return (c < W) ? line[W-1-c] : 1'b0;
    endfunction

    function automatic logic [W-1:0] rx_expect(input logic [31:0] pat, input int n,
                                               input logic fmt, input logic law);
        if (n == W) return pat[W-1:0];
        return {8'h00, pat[7:0] ^ flip_of(fmt, law)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int cycles, input string req);
        for (int c = 0; c < cycles; c++) begin
            @(posedge bclk); #1;
            sdi = NP'($urandom);
            #3;
            for (int p = 0; p < NP; p++) begin
                check(sdo_oe[p] == 1'b0 && sdo[p] == 1'b0, req,
                      {30'd0, sdo_oe[p], sdo[p]}, 32'd0);
            end
            @(negedge bclk);
        end
    endtask

    task automatic run_frame(input string req);
        int mx;
        int base_done [NP];
        int base_err  [NP];
        logic [W-1:0] prev_word [NP];
        mx = (nlen[0] > nlen[1]) ? nlen[0] : nlen[1];
        for (int p = 0; p < NP; p++) begin
            base_done[p] = done_cnt[p];
            base_err[p]  = err_cnt[p];
            prev_word[p] = rx_word[p];
        end
        @(negedge bclk); #1;
        for (int p = 0; p < NP; p++) ena[p] = (nlen[p] > 0);
        for (int c = 0; c < mx; c++) begin
            @(posedge bclk); #1;
            for (int p = 0; p < NP; p++) begin
                if (c < nlen[p]) sdi[p] = rxpat[p][nlen[p]-1-c];
            end
            #3;
            for (int p = 0; p < NP; p++) begin
                if (c < nlen[p]) begin
                    logic eb;
                    eb = tx_bit(tx_word[p], tx_wide[p], cfg_fmt[p], cfg_law[p], c);
                    // R5 R6: serial output bit c, enabled (R7)
                    check(sdo_oe[p] == 1'b1 && sdo[p] == eb, {req, " R5/R6 tx bit"},
                          {30'd0, sdo_oe[p], sdo[p]}, {30'd0, 1'b1, eb});
                end
            end
            @(negedge bclk); #1;
            for (int p = 0; p < NP; p++) begin
                if (c == nlen[p] - 1) ena[p] = 1'b0;
            end
        end
        idle(3, "R7 idle output");
        for (int p = 0; p < NP; p++) begin
            if (nlen[p] == 8 || nlen[p] == W) begin
                logic [W-1:0] ew;
                ew = rx_expect(rxpat[p], nlen[p], cfg_fmt[p], cfg_law[p]);
                check(rx_word[p] == ew, {req, " R2/R3/R4 rx word"}, 32'(rx_word[p]), 32'(ew));
                check(done_cnt[p] == base_done[p] + 1, {req, " R8 done one period"},
                      32'(done_cnt[p] - base_done[p]), 32'd1);
                check(err_cnt[p] == base_err[p], {req, " R9 no error"},
                      32'(err_cnt[p] - base_err[p]), 32'd0);
            end else if (nlen[p] > 0) begin
                check(err_cnt[p] == base_err[p] + 1, {req, " R9 error pulse"},
                      32'(err_cnt[p] - base_err[p]), 32'd1);
                check(done_cnt[p] == base_done[p] && rx_word[p] == prev_word[p],
                      {req, " R9 word kept"}, 32'(rx_word[p]), 32'(prev_word[p]));
            end else begin
                check(done_cnt[p] == base_done[p] && err_cnt[p] == base_err[p] &&
                      rx_word[p] == prev_word[p], {req, " R11 idle port unchanged"},
                      32'(rx_word[p]), 32'(prev_word[p]));
            end
        end
    endtask

    task automatic setup(input int p, input int n, input logic [31:0] pat,
                         input logic fmt, input logic law, input logic wide,
                         input logic [W-1:0] tw);
        nlen[p]    = n;
        rxpat[p]   = pat;
        cfg_fmt[p] = fmt;
        cfg_law[p] = law;
        tx_wide[p] = wide;
        tx_word[p] = tw;
    endtask

    function automatic int pick_len();
        int r;
        r = int'($urandom_range(0, 9));
        if (r < 4) return 8;
        if (r < 8) return W;
        if (r == 8) return 0;
        r = int'($urandom_range(0, 2));
        return (r == 0) ? 5 : ((r == 1) ? 12 : 17);
    endfunction

    initial begin
        void'($urandom(32'h0000_5EED));
        // R1: reset state
        repeat (3) @(posedge bclk_free);
        #1;
        for (int p = 0; p < NP; p++) begin
            check(rx_word[p] == '0 && rx_done[p] == 1'b0 && rx_err[p] == 1'b0,
                  "R1 reset rx outputs", {rx_word[p], 14'd0, rx_done[p], rx_err[p]}, 32'd0);
        end
        @(negedge bclk_free); #1;
        rst_n = 1'b1;
        idle(2, "R1 after reset outputs");
        for (int p = 0; p < NP; p++) begin
            check(rx_word[p] == '0 && done_cnt[p] == 0 && err_cnt[p] == 0,
                  "R1 after reset rx outputs", 32'(rx_word[p]), 32'd0);
        end

        // Directed: both 16-bit
        setup(0, 16, 32'h0000_A5C3, 1'b0, 1'b0, 1'b1, 16'h8001);
        setup(1, 16, 32'h0000_7FFF, 1'b1, 1'b1, 1'b1, 16'h1234);
        run_frame("R2 16/16");
        // Directed: 8-bit sign-magnitude, mixed with 16-bit
        setup(0, 8, 32'h0000_00B7, 1'b0, 1'b0, 1'b0, 16'hFF80);
        setup(1, 16, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        run_frame("R3 R11 8/16");
        // Directed: mu-law full-scale codes, A-law zero codes
        setup(0, 8, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 16'h007F);
        setup(1, 8, 32'h0000_00D5, 1'b1, 1'b1, 1'b0, 16'h0000);
        run_frame("R4 mu/A");
        // Directed: bad lengths, other port idle
        setup(0, 12, 32'h0000_0ABC, 1'b0, 1'b0, 1'b1, 16'hC0DE);
        setup(1, 0, 32'h0, 1'b0, 1'b0, 1'b1, 16'h0);
        run_frame("R9 len12");
        setup(0, 17, 32'h0001_2345, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        setup(1, 5, 32'h0000_0015, 1'b1, 1'b1, 1'b0, 16'h0055);
        run_frame("R9 len17/5");

        // R10: stop the clock between windows and toggle inputs
        @(negedge bclk_free); #1;
        clk_run = 1'b0;
        for (int k = 0; k < 8; k++) begin
            sdi = NP'($urandom);
            #(PERIOD);
            check(sdo_oe == '0 && sdo == '0, "R10 stopped clock outputs",
                  {28'd0, sdo_oe, sdo}, 32'd0);
        end
        @(negedge bclk_free); #1;
        clk_run = 1'b1;
        setup(0, 16, 32'h0000_3C3C, 1'b0, 1'b0, 1'b1, 16'h5AA5);
        setup(1, 8, 32'h0000_0081, 1'b1, 1'b0, 1'b0, 16'h00FE);
        run_frame("R10 after stop");

        // Random frames
        for (int f = 0; f < 40; f++) begin
            for (int p = 0; p < NP; p++) begin
                setup(p, pick_len(), $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                      W'($urandom));
            end
            run_frame("R11 random");
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule